// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block is the digital core of a processor supervisor. It receives an already registered flag that says whether the supply is above its reset threshold. It also receives a watchdog strobe with three levels: low, high and floating. From these inputs it drives a low-line flag, a pair of reset outputs of opposite polarity, and a watchdog fault output.

Reset is held while the supply is low. After the supply recovers, reset is stretched for a fixed number of timebase ticks. If the processor stops toggling the strobe, the block raises a fault and issues a reset pulse of the same fixed length. The fault output stays asserted until the processor toggles the strobe again.

The timebase tick comes from either an internal or an external source, chosen by a select input. With the internal source, a second input picks a short or a long watchdog timeout. All three timeouts are parameters counted in ticks. The strobe is encoded on two bits: `00` is low, `01` is high, and `1x` is floating.

Top module: `supervisor_core`

## Requirements
- R1: `low_line_o` equals `vcc_ok_i` in the same cycle, with no register in the path.
- R2: Reset is asserted (`reset_no` low) in any cycle where `vcc_ok_i` is low. After `vcc_ok_i` returns high, reset deasserts on the clock edge that consumes the RST_TICKS-th selected tick. Cycles without a tick do not advance this count.
- R3: While `wdi_i[1]` is 1 (floating), the watchdog does not count, and `wdo_no` is high from the next edge on.
- R4: Suppose `wdi_i` holds the same low (`00`) or high (`01`) level for the selected timeout number of ticks, counted from the first edge that sees the level. Then, on the edge that consumes the last such tick, `wdo_no` goes low and reset asserts for RST_TICKS ticks.
- R5: Once low, `wdo_no` stays low through the reset pulse and after it. It returns high only on an edge that sees a change between `00` and `01`, or a floating level.
- R6: With `osc_ext_i`=0, ticks come from `tick_int_i`; `fast_i`=1 selects WD_SHORT and `fast_i`=0 selects WD_LONG. With `osc_ext_i`=1, ticks come from `tick_ext_i`, WD_LONG applies, and `fast_i` has no effect.
- R7: `reset_o` is always the inverse of `reset_no`.
- R8: Entering or leaving the floating level clears the watchdog count without a fault. A full timeout is then needed from the next stable low or high level.
- R9: The watchdog count is held at zero while reset is asserted. It starts counting on the first edge after reset deasserts.
- R10: If the supply drops during a watchdog reset pulse, the full RST_TICKS count restarts once the supply recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vcc_ok_i | input | 1 | Registered flag: supply above threshold |
| wdi_i | input | 2 | Watchdog strobe: 00 low, 01 high, 1x floating |
| osc_ext_i | input | 1 | 1 selects the external tick source |
| fast_i | input | 1 | 1 selects the short watchdog timeout (internal source only) |
| tick_int_i | input | 1 | Single-cycle tick from the internal timebase |
| tick_ext_i | input | 1 | Single-cycle tick from the external timebase |
| low_line_o | output | 1 | Low while the supply is below threshold |
| reset_no | output | 1 | Active-low reset |
| reset_o | output | 1 | Active-high reset |
| wdo_no | output | 1 | Active-low watchdog fault |

## Verification
The assertions assume the following about the inputs:
- `vcc_ok_i` and `wdi_i` are synchronous to `clk_i` and already free of glitches.
- Each tick is a single-cycle strobe.
- The timeout parameters are at least one.

The hold property on the fault output compares the strobe with its previous value. It therefore assumes the strobe changes only at clock edges.

The stimulus follows these assumptions:
- Every input is changed only on the falling clock edge.
- Ticks are driven as per-cycle levels that the bench chooses directly.
- The parameters are overridden to small values, so every timeout ends within a few cycles.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WDI_LO = 2'b00,
    WDI_HI = 2'b01,
    WDI_FL = 2'b10
  } wdi_lvl_e;

  function automatic logic wdi_float(logic [1:0] lvl);
    return lvl[1];
  endfunction
endpackage

// File: rtl/sup_tick_sel.sv
module sup_tick_sel #(
  parameter int unsigned WD_SHORT = 16,
  parameter int unsigned WD_LONG  = 256,
  parameter int unsigned CW       = 9
) (
  input  logic          osc_ext_i,
  input  logic          fast_i,
  input  logic          tick_int_i,
  input  logic          tick_ext_i,
  output logic          tick_o,
  output logic [CW-1:0] limit_o
);
  localparam logic [CW-1:0] SHORT_C = CW'(WD_SHORT);
  localparam logic [CW-1:0] LONG_C  = CW'(WD_LONG);

  always_comb begin
    if (osc_ext_i) begin
      tick_o  = tick_ext_i;
      limit_o = LONG_C;
    end else begin
      tick_o  = tick_int_i;
      limit_o = fast_i ? SHORT_C : LONG_C;
    end
  end
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic tick_i,
  input  logic trip_i,
  output logic rst_act_o
);
  localparam int unsigned RW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
  localparam logic [RW-1:0] LAST_C = RW'(RST_TICKS - 1);

  logic          act_q;
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (!vcc_ok_i || trip_i) begin
      // supply loss or watchdog trip restarts the full stretch
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick_i) begin
      if (cnt_q == LAST_C) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_act_o = act_q || !vcc_ok_i;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    wdi_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  input  logic          hold_i,
  output logic          trip_o,
  output logic          wdo_no
);
  import sup_pkg::*;

  logic [1:0]    prev_q;
  logic [CW-1:0] cnt_q;
  logic          wdo_q;
  logic          flt, chg, edge_lh, at_lim;

  assign flt     = wdi_float(wdi_i);
  assign chg     = (wdi_i != prev_q);
  assign edge_lh = !flt && !wdi_float(prev_q) && (wdi_i[0] != prev_q[0]);
  assign at_lim  = (cnt_q == limit_i - 1'b1);
  assign trip_o  = tick_i && !hold_i && !flt && !chg && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= WDI_FL;
      cnt_q  <= '0;
      wdo_q  <= 1'b1;
    end else begin
      prev_q <= wdi_i;
      if (hold_i || flt || chg || trip_o) cnt_q <= '0;
      else if (tick_i)                    cnt_q <= cnt_q + 1'b1;
      if (edge_lh || flt) wdo_q <= 1'b1;
      else if (trip_o)    wdo_q <= 1'b0;
    end
  end

  assign wdo_no = wdo_q;
endmodule

// File: rtl/supervisor_core.sv
module supervisor_core #(
  parameter int unsigned RST_TICKS = 200,
  parameter int unsigned WD_SHORT  = 16,
  parameter int unsigned WD_LONG   = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_ok_i,
  input  logic [1:0] wdi_i,
  input  logic       osc_ext_i,
  input  logic       fast_i,
  input  logic       tick_int_i,
  input  logic       tick_ext_i,
  output logic       low_line_o,
  output logic       reset_no,
  output logic       reset_o,
  output logic       wdo_no
);
  localparam int unsigned WD_MAX = (WD_LONG > WD_SHORT) ? WD_LONG : WD_SHORT;
  localparam int unsigned CW     = $clog2(WD_MAX + 1);

  logic          tick;
  logic [CW-1:0] limit;
  logic          trip;
  logic          rst_act;

  sup_tick_sel #(.WD_SHORT(WD_SHORT), .WD_LONG(WD_LONG), .CW(CW)) i_tick_sel (
    .osc_ext_i (osc_ext_i),
    .fast_i    (fast_i),
    .tick_int_i(tick_int_i),
    .tick_ext_i(tick_ext_i),
    .tick_o    (tick),
    .limit_o   (limit)
  );

  sup_rst_timer #(.RST_TICKS(RST_TICKS)) i_rst_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vcc_ok_i (vcc_ok_i),
    .tick_i   (tick),
    .trip_i   (trip),
    .rst_act_o(rst_act)
  );

  sup_wdog #(.CW(CW)) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wdi_i  (wdi_i),
    .tick_i (tick),
    .limit_i(limit),
    .hold_i (rst_act),
    .trip_o (trip),
    .wdo_no (wdo_no)
  );

  assign low_line_o = vcc_ok_i;
  assign reset_o    = rst_act;
  assign reset_no   = ~rst_act;
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_ok_i,
  input logic [1:0] wdi_i,
  input logic       low_line_o,
  input logic       reset_no,
  input logic       reset_o,
  input logic       wdo_no
);
  // R1
  low_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_line_o == vcc_ok_i);

  // R2
  low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |-> !reset_no);

  // R3
  float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdi_i[1] |=> wdo_no);

  // R4
  trip_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_no) |-> !reset_no);

  // R5
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdo_no && !wdi_i[1] && wdi_i == $past(wdi_i)) |=> !wdo_no);

  // R7
  polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o != reset_no);
endmodule

bind supervisor_core sup_chk i_sup_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vcc_ok_i  (vcc_ok_i),
  .wdi_i     (wdi_i),
  .low_line_o(low_line_o),
  .reset_no  (reset_no),
  .reset_o   (reset_o),
  .wdo_no    (wdo_no)
);

// File: tb/test_supervisor_core.sv
module test_supervisor_core;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, FL = 2'b10;

  typedef struct {
    logic  rn;
    logic  wdo;
    logic  ll;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0;
  logic [1:0] wdi = FL;
  logic osc_ext = 1'b0, fast = 1'b1, tick_int = 1'b0, tick_ext = 1'b0;
  logic low_line, reset_n, reset_p, wdo_n;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supervisor_core #(.RST_TICKS(4), .WD_SHORT(3), .WD_LONG(6)) i_supervisor_core (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok), .wdi_i(wdi),
    .osc_ext_i(osc_ext), .fast_i(fast), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
    .low_line_o(low_line), .reset_no(reset_n), .reset_o(reset_p), .wdo_no(wdo_n)
  );

  // driver: apply one cycle of stimulus and queue the outputs expected after the next edge
  task automatic cyc(input logic v, input logic [1:0] w, input logic ext, input logic fs,
                     input logic ti, input logic te, input logic rn, input logic wdo,
                     input string req);
    exp_t e;
    @(negedge clk);
    vcc_ok = v; wdi = w; osc_ext = ext; fast = fs; tick_int = ti; tick_ext = te;
    e.rn = rn; e.wdo = wdo; e.ll = v; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (reset_n !== e.rn) begin
          miscompares++;
          $display("FAIL %s reset_no act=%b exp=%b", e.req, reset_n, e.rn);
        end
        if (wdo_n !== e.wdo) begin
          miscompares++;
          $display("FAIL %s wdo_no act=%b exp=%b", e.req, wdo_n, e.wdo);
        end
        if (low_line !== e.ll) begin
          miscompares++;
          $display("FAIL R1 low_line_o act=%b exp=%b", low_line, e.ll);
        end
        if (reset_p !== ~e.rn) begin
          miscompares++;
          $display("FAIL R7 reset_o act=%b exp=%b", reset_p, ~e.rn);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // reset state
    cyc(0, FL, 0, 1, 1, 0, 0, 1, "R2 reset state");
    @(negedge clk); rst_n = 1'b1;
    // R2 power-up stretch, gap in ticks does not count
    cyc(0, FL, 0, 1, 1, 0, 0, 1, "R2");
    cyc(1, FL, 0, 1, 1, 0, 0, 1, "R2");
    cyc(1, FL, 0, 1, 0, 0, 0, 1, "R2");
    cyc(1, FL, 0, 1, 1, 0, 0, 1, "R2");
    cyc(1, FL, 0, 1, 1, 0, 0, 1, "R2");
    cyc(1, FL, 0, 1, 1, 0, 1, 1, "R2");
    // R4 short timeout on steady low
    cyc(1, LO, 0, 1, 1, 0, 1, 1, "R4");
    cyc(1, LO, 0, 1, 1, 0, 1, 1, "R4");
    cyc(1, LO, 0, 1, 1, 0, 1, 1, "R4");
    cyc(1, LO, 0, 1, 1, 0, 0, 0, "R4");
    repeat (3) cyc(1, LO, 0, 1, 1, 0, 0, 0, "R4");
    cyc(1, LO, 0, 1, 1, 0, 1, 0, "R5");
    // R9 count starts only after release
    cyc(1, LO, 0, 1, 1, 0, 1, 0, "R9");
    cyc(1, LO, 0, 1, 1, 0, 1, 0, "R9");
    cyc(1, LO, 0, 1, 1, 0, 0, 0, "R9");
    repeat (3) cyc(1, LO, 0, 1, 1, 0, 0, 0, "R9");
    cyc(1, HI, 0, 1, 1, 0, 1, 1, "R5");
    // R3 / R8 floating level
    cyc(1, HI, 0, 1, 1, 0, 1, 1, "R8");
    cyc(1, FL, 0, 1, 1, 0, 1, 1, "R8");
    repeat (4) cyc(1, FL, 0, 1, 1, 0, 1, 1, "R3");
    cyc(1, HI, 0, 1, 1, 0, 1, 1, "R8");
    cyc(1, HI, 0, 1, 1, 0, 1, 1, "R8");
    cyc(1, FL, 0, 1, 1, 0, 1, 1, "R8");
    repeat (3) cyc(1, HI, 0, 1, 1, 0, 1, 1, "R8");
    cyc(1, HI, 0, 1, 1, 0, 0, 0, "R8");
    // R5 fault clears on a transition during the pulse
    cyc(1, LO, 0, 1, 1, 0, 0, 1, "R5");
    cyc(1, LO, 0, 1, 1, 0, 0, 1, "R5");
    cyc(1, LO, 0, 1, 1, 0, 0, 1, "R5");
    cyc(1, LO, 0, 1, 1, 0, 1, 1, "R2");
    // R6 long timeout on internal source
    cyc(1, HI, 0, 0, 1, 0, 1, 1, "R6");
    repeat (5) cyc(1, HI, 0, 0, 1, 0, 1, 1, "R6");
    cyc(1, HI, 0, 0, 1, 0, 0, 0, "R6");
    repeat (3) cyc(1, FL, 0, 0, 1, 0, 0, 1, "R3");
    cyc(1, FL, 0, 0, 1, 0, 1, 1, "R2");
    // R6 external source: long timeout, internal ticks and fast ignored
    cyc(1, LO, 1, 1, 1, 0, 1, 1, "R6");
    repeat (6) cyc(1, LO, 1, 1, 1, 0, 1, 1, "R6");
    repeat (5) cyc(1, LO, 1, 1, 0, 1, 1, 1, "R6");
    cyc(1, LO, 1, 1, 0, 1, 0, 0, "R6");
    repeat (3) cyc(1, FL, 1, 1, 0, 1, 0, 1, "R6");
    cyc(1, FL, 1, 1, 1, 0, 0, 1, "R6");
    cyc(1, FL, 1, 1, 0, 1, 1, 1, "R6");
    // R10 supply drop during watchdog pulse
    repeat (3) cyc(1, HI, 0, 1, 1, 0, 1, 1, "R4");
    cyc(1, HI, 0, 1, 1, 0, 0, 0, "R4");
    cyc(1, HI, 0, 1, 1, 0, 0, 0, "R10");
    cyc(1, HI, 0, 1, 1, 0, 0, 0, "R10");
    cyc(0, HI, 0, 1, 1, 0, 0, 0, "R10");
    cyc(0, HI, 0, 1, 1, 0, 0, 0, "R1");
    repeat (3) cyc(1, HI, 0, 1, 1, 0, 0, 0, "R10");
    cyc(1, HI, 0, 1, 1, 0, 1, 0, "R10");
    cyc(1, LO, 0, 1, 1, 0, 1, 1, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule